// File: doc/BRIEF.md
# Multiplexed-Bus Clock and Memory Front End

This block is the host-facing front end of a clock-plus-memory device. A host reaches two separate address spaces over one shared 8-bit address/data bus. The first is a 64-location clock register file. The second is a 4 KB static RAM.

Each address space has its own address strobes. While a strobe is high, its address register follows the bus. When the strobe falls, the register holds. The clock space uses one strobe for a single offset byte. The RAM space uses two strobes: one for the low address byte and one for the high address bits.

The block decodes each clock offset into one of three zones: timekeeping bytes, control registers and general user bytes. It turns the end of each write strobe into a single-cycle write pulse toward the neighbouring storage. It also places read data on the shared bus under an output enable. Every write is held back until the power-good input is high. Writes to the timekeeping bytes are also held back while the neighbouring counters report an update in progress. The control registers and the user bytes stay open during an update.

Top module: `mux_rtc_sram_if`

## Requirements
- R1: While `ale` is high at a clock edge, the clock-offset register loads `bus_in`. While `ale` is low, it holds. `rf_addr` carries the low 6 bits of that register.
- R2: `as_lo` loads `bus_in` into `ram_addr[7:0]`. `as_hi` loads only `bus_in[3:0]` into `ram_addr[11:8]`, and the upper nibble of that byte is ignored. Each register holds while its strobe is low.
- R3: Zone decode of the latched clock offset: offsets 0..9 raise `sel_time`, offsets 10..13 raise `sel_ctrl`, and offsets 14..63 raise `sel_user`. At most one of the three is high at any time.
- R4: A rising edge of `wr_n` while `cs_n` is low produces `rf_wr` high for exactly one cycle, in the cycle after the edge. `wr_data` then holds the last bus value sampled while `wr_n` was low.
- R5: A rising edge of `ram_we_n` while `cs_n` is low produces `ram_wr` high for exactly one cycle, in the cycle after the edge, at the latched `ram_addr`.
- R6: While `pwr_ok` is low, neither `rf_wr` nor `ram_wr` is produced. Stored contents therefore read back unchanged.
- R7: While `upd_busy` is high, a write to offsets 0..9 produces no `rf_wr`. Writes to offsets 10..63 still pass.
- R8: A clock offset with latched bits 7:6 not zero is out of range. A write to it produces no pulse and does not alias onto a low offset. A read of it returns 0x00, and all three zone selects stay low.
- R9: `bus_oe` is high only while `cs_n` is low and either `rd_n` or `ram_oe_n` is low. `bus_out` carries `rf_rdata` when `rd_n` is low, and `ram_rdata` when only `ram_oe_n` is low.
- R10: After reset, `rf_addr` and `ram_addr` are zero, and `rf_wr`, `ram_wr` and `bus_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pwr_ok | input | 1 | Power good; writes are allowed only while high |
| upd_busy | input | 1 | Timekeeping update in progress |
| cs_n | input | 1 | Active-low chip select |
| ale | input | 1 | Clock-offset address strobe |
| as_lo | input | 1 | RAM low-address strobe |
| as_hi | input | 1 | RAM high-address strobe |
| rd_n | input | 1 | Clock-section read enable, active low |
| wr_n | input | 1 | Clock-section write strobe, active low |
| ram_oe_n | input | 1 | RAM read enable, active low |
| ram_we_n | input | 1 | RAM write strobe, active low |
| bus_in | input | 8 | Shared bus, inbound |
| bus_out | output | 8 | Shared bus, outbound read data |
| bus_oe | output | 1 | Bus driver enable |
| rf_addr | output | 6 | Register-file offset |
| sel_time | output | 1 | Offset is in the timekeeping zone |
| sel_ctrl | output | 1 | Offset is in the control zone |
| sel_user | output | 1 | Offset is in the user zone |
| rf_wr | output | 1 | Register-file write pulse |
| rf_rdata | input | 8 | Register-file read data |
| ram_addr | output | 12 | RAM address |
| ram_wr | output | 1 | RAM write pulse |
| ram_rdata | input | 8 | RAM read data |
| wr_data | output | 8 | Write data for either store |

## Verification
The bench builds the block with its defaults: an 8-bit bus, 6 offset bits, 12 RAM address bits, 10 timekeeping bytes and 4 control bytes. With these values the bench can reach the extreme RAM addresses 0x000 and 0xFFF and the top offset 63. It can also reach both zone edges, 9/10 and 13/14, and out-of-range offsets such as 0x45, whose low bits alias onto a real register. Bench-side models of the register file and the RAM let every write, or every suppressed write, be confirmed by reading it back over the shared bus.

// File: rtl/mux_rtc_sram_if.sv
module mux_rtc_sram_if #(
  parameter int DW         = 8,
  parameter int RF_AW      = 6,
  parameter int RAM_AW     = 12,
  parameter int TIME_BYTES = 10,
  parameter int CTRL_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_ok,
  input  logic              upd_busy,
  input  logic              cs_n,
  input  logic              ale,
  input  logic              as_lo,
  input  logic              as_hi,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              ram_oe_n,
  input  logic              ram_we_n,
  input  logic [DW-1:0]     bus_in,
  output logic [DW-1:0]     bus_out,
  output logic              bus_oe,
  output logic [RF_AW-1:0]  rf_addr,
  output logic              sel_time,
  output logic              sel_ctrl,
  output logic              sel_user,
  output logic              rf_wr,
  input  logic [DW-1:0]     rf_rdata,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_wr,
  input  logic [DW-1:0]     ram_rdata,
  output logic [DW-1:0]     wr_data
);
  localparam int HI_BITS  = RAM_AW - DW;
  localparam int CTRL_END = TIME_BYTES + CTRL_BYTES;

  logic [DW-1:0]      off_q, lo_q, wd_q;
  logic [HI_BITS-1:0] hi_q;
  logic               wr_prev, we_prev, rf_wr_q, ram_wr_q;
  logic               in_range, rf_rd, ram_rd;

  assign rf_addr  = off_q[RF_AW-1:0];
  assign in_range = (off_q[DW-1:RF_AW] == '0);
  assign sel_time = in_range && (rf_addr <  RF_AW'(TIME_BYTES));
  assign sel_ctrl = in_range && (rf_addr >= RF_AW'(TIME_BYTES)) && (rf_addr < RF_AW'(CTRL_END));
  assign sel_user = in_range && (rf_addr >= RF_AW'(CTRL_END));

  assign ram_addr = {hi_q, lo_q};
  assign rf_wr    = rf_wr_q;
  assign ram_wr   = ram_wr_q;
  assign wr_data  = wd_q;

  assign rf_rd   = !cs_n && !rd_n;
  assign ram_rd  = !cs_n && rd_n && !ram_oe_n;
  assign bus_oe  = rf_rd || ram_rd;
  assign bus_out = rf_rd  ? (in_range ? rf_rdata : '0) :
                   ram_rd ? ram_rdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q    <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      wd_q     <= '0;
      wr_prev  <= 1'b1;
      we_prev  <= 1'b1;
      rf_wr_q  <= 1'b0;
      ram_wr_q <= 1'b0;
    end else begin
      if (ale)   off_q <= bus_in;
      if (as_lo) lo_q  <= bus_in;
      if (as_hi) hi_q  <= bus_in[HI_BITS-1:0];
      if (!wr_n || !ram_we_n) wd_q <= bus_in;
      wr_prev  <= wr_n;
      we_prev  <= ram_we_n;
      rf_wr_q  <= !cs_n && wr_n && !wr_prev && pwr_ok && in_range &&
                  !(sel_time && upd_busy);
      ram_wr_q <= !cs_n && ram_we_n && !we_prev && pwr_ok;
    end
  end
endmodule

// File: rtl/mux_rtc_sram_if_chk.sv
module mux_rtc_sram_if_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pwr_ok,
  input logic        upd_busy,
  input logic        cs_n,
  input logic        ale,
  input logic        as_hi,
  input logic        bus_oe,
  input logic [5:0]  rf_addr,
  input logic        sel_time,
  input logic        sel_ctrl,
  input logic        sel_user,
  input logic        rf_wr,
  input logic [11:0] ram_addr,
  input logic        ram_wr
);
  AST_OFFSET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ale) |-> $stable(rf_addr)); // R1
  AST_HIGH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(as_hi) |-> $stable(ram_addr[11:8])); // R2
  AST_ZONE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_time, sel_ctrl, sel_user})); // R3
  AST_RF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr |=> !rf_wr); // R4
  AST_RAM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr |=> !ram_wr); // R5
  AST_WRITE_POWER: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_wr || ram_wr) |-> $past(pwr_ok)); // R6
  AST_BUSY_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_wr && sel_time) |-> !$past(upd_busy)); // R7
  AST_WRITE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr |-> (sel_time || sel_ctrl || sel_user)); // R8
  AST_OE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !cs_n); // R9
endmodule

bind mux_rtc_sram_if mux_rtc_sram_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .upd_busy(upd_busy),
  .cs_n(cs_n), .ale(ale), .as_hi(as_hi), .bus_oe(bus_oe),
  .rf_addr(rf_addr), .sel_time(sel_time), .sel_ctrl(sel_ctrl),
  .sel_user(sel_user), .rf_wr(rf_wr), .ram_addr(ram_addr), .ram_wr(ram_wr)
);

// File: tb/sim_mux_rtc_sram_if.sv
module sim_mux_rtc_sram_if;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pwr_ok = 1'b1, upd_busy = 1'b0, cs_n = 1'b1;
  logic ale = 1'b0, as_lo = 1'b0, as_hi = 1'b0;
  logic rd_n = 1'b1, wr_n = 1'b1, ram_oe_n = 1'b1, ram_we_n = 1'b1;
  logic [7:0]  bus_in = 8'h00, bus_out, rf_rdata, ram_rdata, wr_data;
  logic        bus_oe, sel_time, sel_ctrl, sel_user, rf_wr, ram_wr;
  logic [5:0]  rf_addr;
  logic [11:0] ram_addr;
  logic [7:0]  rf_mem [64];
  logic [7:0]  ram_mem [4096];
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  mux_rtc_sram_if u0 (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .upd_busy(upd_busy),
    .cs_n(cs_n), .ale(ale), .as_lo(as_lo), .as_hi(as_hi), .rd_n(rd_n),
    .wr_n(wr_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .rf_addr(rf_addr),
    .sel_time(sel_time), .sel_ctrl(sel_ctrl), .sel_user(sel_user),
    .rf_wr(rf_wr), .rf_rdata(rf_rdata), .ram_addr(ram_addr),
    .ram_wr(ram_wr), .ram_rdata(ram_rdata), .wr_data(wr_data)
  );

  initial begin
    for (int i = 0; i < 64; i++) rf_mem[i] = 8'h00;
    for (int i = 0; i < 4096; i++) ram_mem[i] = 8'h00;
  end
  always @(posedge clk) begin
    if (rf_wr)  rf_mem[rf_addr]   <= wr_data;
    if (ram_wr) ram_mem[ram_addr] <= wr_data;
  end
  assign rf_rdata  = rf_mem[rf_addr];
  assign ram_rdata = ram_mem[ram_addr];

  // {is_ram, address[11:0], data[7:0]}
  localparam logic [20:0] VEC [8] = '{
    {1'b0, 12'h000, 8'h31}, {1'b0, 12'h00B, 8'h2C},
    {1'b0, 12'h00E, 8'hA5}, {1'b0, 12'h03F, 8'h7E},
    {1'b1, 12'h000, 8'h11}, {1'b1, 12'hFFF, 8'hF0},
    {1'b1, 12'h5A3, 8'h3C}, {1'b1, 12'h800, 8'h88}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rf_latch(input logic [7:0] a);
    @(negedge clk); cs_n = 1'b0; ale = 1'b1; bus_in = a;
    @(negedge clk); ale = 1'b0; bus_in = 8'h00;
  endtask

  task automatic rf_write(input logic [7:0] a, input logic [7:0] d, input logic pulse, input string req);
    rf_latch(a);
    @(negedge clk); wr_n = 1'b0; bus_in = d;
    @(negedge clk); wr_n = 1'b1; bus_in = 8'h00;
    @(negedge clk); check(req, {rf_wr, (pulse ? wr_data : 8'h00)}, {pulse, (pulse ? d : 8'h00)});
    @(negedge clk); cs_n = 1'b1;
  endtask

  task automatic rf_read(input logic [7:0] a, input logic [7:0] exp, input string req);
    rf_latch(a);
    @(negedge clk); rd_n = 1'b0;
    #2 check(req, {bus_oe, bus_out}, {1'b1, exp});
    @(negedge clk); rd_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic ram_latch(input logic [7:0] hb, input logic [7:0] lb);
    @(negedge clk); cs_n = 1'b0; as_lo = 1'b1; bus_in = lb;
    @(negedge clk); as_lo = 1'b0; as_hi = 1'b1; bus_in = hb;
    @(negedge clk); as_hi = 1'b0; bus_in = 8'h00;
  endtask

  task automatic ram_write(input logic [11:0] a, input logic [7:0] d, input logic pulse, input string req);
    ram_latch({4'h0, a[11:8]}, a[7:0]);
    @(negedge clk); ram_we_n = 1'b0; bus_in = d;
    @(negedge clk); ram_we_n = 1'b1; bus_in = 8'h00;
    @(negedge clk); check(req, {ram_wr, ram_addr}, {pulse, a});
    @(negedge clk); cs_n = 1'b1;
  endtask

  task automatic ram_read(input logic [11:0] a, input logic [7:0] exp, input string req);
    ram_latch({4'h0, a[11:8]}, a[7:0]);
    @(negedge clk); ram_oe_n = 1'b0;
    #2 check(req, {bus_oe, bus_out}, {1'b1, exp});
    @(negedge clk); ram_oe_n = 1'b1; cs_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset state", {rf_addr, ram_addr, rf_wr, ram_wr, bus_oe}, '0);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++)
      if (VEC[i][20]) ram_write(VEC[i][19:8], VEC[i][7:0], 1'b1, "R5 ram write pulse");
      else            rf_write(VEC[i][15:8], VEC[i][7:0], 1'b1, "R4 rf write pulse");
    for (int i = 0; i < 8; i++)
      if (VEC[i][20]) ram_read(VEC[i][19:8], VEC[i][7:0], "R9 ram readback");
      else            rf_read(VEC[i][15:8], VEC[i][7:0], "R9 rf readback");

    rf_latch(8'h2A); check("R1 offset latched", rf_addr, 6'h2A);
    @(negedge clk); bus_in = 8'h13;
    @(negedge clk); check("R1 offset held with strobe low", rf_addr, 6'h2A);
    cs_n = 1'b1;

    ram_latch(8'hF5, 8'h10); check("R2 upper nibble ignored", ram_addr, 12'h510);
    cs_n = 1'b1;

    rf_latch(8'h09); check("R3 offset 9 timekeeping", {sel_time, sel_ctrl, sel_user}, 3'b100);
    rf_latch(8'h0A); check("R3 offset 10 control", {sel_time, sel_ctrl, sel_user}, 3'b010);
    rf_latch(8'h0D); check("R3 offset 13 control", {sel_time, sel_ctrl, sel_user}, 3'b010);
    rf_latch(8'h0E); check("R3 offset 14 user", {sel_time, sel_ctrl, sel_user}, 3'b001);
    rf_latch(8'h80); check("R8 out of range no zone", {sel_time, sel_ctrl, sel_user}, 3'b000);
    cs_n = 1'b1;

    pwr_ok = 1'b0;
    ram_write(12'h000, 8'h99, 1'b0, "R6 ram write blocked");
    rf_write(8'h0E, 8'h99, 1'b0, "R6 rf write blocked");
    pwr_ok = 1'b1;
    ram_read(12'h000, 8'h11, "R6 ram unchanged");
    rf_read(8'h0E, 8'hA5, "R6 rf unchanged");

    upd_busy = 1'b1;
    rf_write(8'h02, 8'h77, 1'b0, "R7 time write blocked");
    rf_write(8'h20, 8'h66, 1'b1, "R7 user write passes");
    rf_write(8'h0C, 8'h55, 1'b1, "R7 control write passes");
    upd_busy = 1'b0;
    rf_read(8'h02, 8'h00, "R7 time unchanged");
    rf_read(8'h20, 8'h66, "R7 user written");
    rf_read(8'h0C, 8'h55, "R7 control written");

    rf_write(8'h45, 8'hEE, 1'b0, "R8 out of range write");
    rf_read(8'h05, 8'h00, "R8 no alias");
    rf_read(8'h45, 8'h00, "R8 out of range reads zero");

    @(negedge clk); cs_n = 1'b1; rd_n = 1'b0; ram_oe_n = 1'b0;
    #2 check("R9 no drive without select", bus_oe, 1'b0);
    @(negedge clk); rd_n = 1'b1; ram_oe_n = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule